// File: doc/BRIEF.md
# DMA Transfer Address Generator

This block computes the two addresses a single DMA channel needs for every data item it moves: one on the peripheral side and one on the memory side. When the channel enable goes high, the block captures a new transfer setup. That setup holds both start addresses, the item count, a width code for each side, an increment enable for each side and a flag that pins the peripheral stride to four bytes. From then on, each beat-done pulse from the transfer engine moves both addresses on by their strides and takes one off the item count.

The transfer engine reads the current addresses, the remaining count and a last-item flag straight from the outputs. The usual setup keeps the peripheral address fixed on one data register and walks the memory address through a buffer. A setup with a reserved width code is refused, and an error flag is raised in its place.

Top module: `dma_addr_gen`

## Requirements
- R1: While reset is low, and after it is released with no enable edge yet, `paddr`, `maddr` and `remain` are zero, and `last`, `active` and `cfg_err` are low.
- R2: A rising edge of `en` with legal widths has the following effect one clock later. `paddr` equals `pstart`, `maddr` equals `mstart`, `remain` equals `len` and `active` is high. A `beat_done` in the load cycle is ignored.
- R3: Width codes give the stride: 2'b00 is 1 byte, 2'b01 is 2 bytes and 2'b10 is 4 bytes. With `minc`=1, `maddr` grows by the memory stride on each accepted beat. With `pinc`=1 and `pofs4`=0, `paddr` grows by the peripheral stride on each accepted beat. Addresses wrap modulo 2^AW.
- R4: With `pinc`=0, `paddr` never changes during a transfer. With `minc`=0, `maddr` never changes during a transfer.
- R5: With `pinc`=1 and `pofs4`=1, `paddr` grows by 4 on each accepted beat, whatever `psize` is.
- R6: With `pinc`=0, `pofs4` has no effect, and `paddr` stays at `pstart`.
- R7: Each accepted beat lowers `remain` by one. `last` is high exactly when `remain` equals 1.
- R8: A `beat_done` while `remain` is 0 changes neither address nor the count.
- R9: Once `en` is low, `active` drops on the next clock. Addresses and count then hold their values, and `beat_done` has no effect until the next accepted load.
- R10: If `psize` or `msize` is 2'b11 at an enable edge, `cfg_err` goes high and `active` stays low. Addresses and count keep their old values and beats are ignored. The next accepted load clears `cfg_err`.
- R11: Setup inputs are sampled only at the load. Changing them during a transfer has no effect on the strides or the addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Channel enable; its rising edge loads a transfer |
| pstart | input | AW | Peripheral start address |
| mstart | input | AW | Memory start address |
| len | input | LW | Number of items |
| psize | input | 2 | Peripheral width code |
| msize | input | 2 | Memory width code |
| pinc | input | 1 | Peripheral address increment enable |
| minc | input | 1 | Memory address increment enable |
| pofs4 | input | 1 | Force peripheral stride to 4 bytes |
| beat_done | input | 1 | One item moved; advance |
| paddr | output | AW | Current peripheral address |
| maddr | output | AW | Current memory address |
| remain | output | LW | Items still to move |
| last | output | 1 | Current item is the final one |
| active | output | 1 | A legal transfer is loaded and enabled |
| cfg_err | output | 1 | Last enable edge carried a reserved width |

## Verification
The bench aims at the four-byte override with the peripheral increment both on and off. A design that gates the override wrongly would step a fixed register address, or step by the bus width instead of 4. It also sends beats into an exhausted count, where a careless decrement would wrap `remain` to its maximum and let the addresses run on. It changes the setup inputs in the middle of a transfer and drops the enable with beats still arriving, which shows up any design that reads the live inputs or keeps stepping after disable. Reserved width codes must leave the channel idle with the error flag high. A design that loaded anyway would step with a wrong stride.

// File: rtl/dma_addr_gen.sv
module dma_addr_gen #(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [AW-1:0] pstart,
  input  logic [AW-1:0] mstart,
  input  logic [LW-1:0] len,
  input  logic [1:0]    psize,
  input  logic [1:0]    msize,
  input  logic          pinc,
  input  logic          minc,
  input  logic          pofs4,
  input  logic          beat_done,
  output logic [AW-1:0] paddr,
  output logic [AW-1:0] maddr,
  output logic [LW-1:0] remain,
  output logic          last,
  output logic          active,
  output logic          cfg_err
);
  localparam logic [1:0] W_RSV = 2'b11;
  localparam int SW = 3;

  logic          en_q;
  logic [SW-1:0] pstep, mstep;
  logic          load, bad, go;

  function automatic logic [SW-1:0] stride(input logic [1:0] w);
    case (w)
      2'b00:   return SW'(1);
      2'b01:   return SW'(2);
      default: return SW'(4);
    endcase
  endfunction

  assign load = en & ~en_q;
  assign bad  = (psize == W_RSV) | (msize == W_RSV);
  assign go   = active & en & beat_done & (remain != '0);
  assign last = (remain == LW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      active  <= 1'b0;
      cfg_err <= 1'b0;
      paddr   <= '0;
      maddr   <= '0;
      remain  <= '0;
      pstep   <= '0;
      mstep   <= '0;
    end else begin
      en_q <= en;
      if (load) begin
        if (bad) begin
          cfg_err <= 1'b1;
          active  <= 1'b0;
        end else begin
          cfg_err <= 1'b0;
          active  <= 1'b1;
          paddr   <= pstart;
          maddr   <= mstart;
          remain  <= len;
          pstep   <= !pinc ? '0 : (pofs4 ? SW'(4) : stride(psize));
          mstep   <= minc ? stride(msize) : '0;
        end
      end else begin
        if (!en) active <= 1'b0;
        if (go) begin
          paddr  <= paddr + {{(AW-SW){1'b0}}, pstep};
          maddr  <= maddr + {{(AW-SW){1'b0}}, mstep};
          remain <= remain - LW'(1);
        end
      end
    end
  end
endmodule

module dma_addr_gen_chk #(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          beat_done,
  input logic [AW-1:0] paddr,
  input logic [AW-1:0] maddr,
  input logic [LW-1:0] remain,
  input logic          active,
  input logic          cfg_err
);
  p_freeze_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(paddr) && $stable(maddr) && $stable(remain)));

  p_dec_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (active && en && beat_done && remain != '0) |=> (remain == $past(remain) - LW'(1)));

  p_stall_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (active && en && remain == '0) |=> (remain == '0 && $stable(paddr) && $stable(maddr)));

  p_err_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !active);

  p_mstride_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && en && beat_done && remain != '0) |=>
      ((maddr - $past(maddr)) inside {AW'(0), AW'(1), AW'(2), AW'(4)}));

  p_pstride_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (active && en && beat_done && remain != '0) |=>
      ((paddr - $past(paddr)) inside {AW'(0), AW'(1), AW'(2), AW'(4)}));
endmodule

bind dma_addr_gen dma_addr_gen_chk #(.AW(AW), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .beat_done(beat_done),
  .paddr(paddr), .maddr(maddr), .remain(remain),
  .active(active), .cfg_err(cfg_err)
);

// File: tb/dma_addr_gen_test.sv
`timescale 1ns/1ps
module dma_addr_gen_test;
  localparam int AW = 32;
  localparam int LW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, pinc = 1'b0, minc = 1'b0, pofs4 = 1'b0, beat = 1'b0;
  logic [1:0] psz = '0, msz = '0;
  logic [AW-1:0] ps = '0, ms = '0;
  logic [LW-1:0] len = '0;
  logic [AW-1:0] paddr, maddr;
  logic [LW-1:0] remain;
  logic last, active, cfg_err;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  dma_addr_gen #(.AW(AW), .LW(LW)) uut (
    .clk(clk), .rst_n(rst_n), .en(en), .pstart(ps), .mstart(ms), .len(len),
    .psize(psz), .msize(msz), .pinc(pinc), .minc(minc), .pofs4(pofs4),
    .beat_done(beat), .paddr(paddr), .maddr(maddr), .remain(remain),
    .last(last), .active(active), .cfg_err(cfg_err)
  );

  // reference model built from the requirements
  logic m_enq, m_act, m_err, m_pinc, m_pofs;
  logic [AW-1:0] m_pa, m_ma, m_pst, m_mst;
  logic [LW-1:0] m_rem;

  function automatic logic [AW-1:0] width_bytes(input logic [1:0] w);
    return (w == 2'b00) ? AW'(1) : (w == 2'b01) ? AW'(2) : AW'(4);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_enq <= 0; m_act <= 0; m_err <= 0; m_pinc <= 0; m_pofs <= 0;
      m_pa <= '0; m_ma <= '0; m_pst <= '0; m_mst <= '0; m_rem <= '0;
    end else begin
      m_enq <= en;
      if (en && !m_enq) begin
        if (psz == 2'b11 || msz == 2'b11) begin
          m_err <= 1; m_act <= 0;
        end else begin
          m_err <= 0; m_act <= 1;
          m_pa <= ps; m_ma <= ms; m_rem <= len;
          m_pinc <= pinc; m_pofs <= pofs4;
          m_pst <= !pinc ? '0 : pofs4 ? AW'(4) : width_bytes(psz);
          m_mst <= minc ? width_bytes(msz) : '0;
        end
      end else begin
        if (!en) m_act <= 0;
        if (m_act && en && beat && m_rem != 0) begin
          m_pa <= m_pa + m_pst; m_ma <= m_ma + m_mst; m_rem <= m_rem - 1;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    string ptag;
    ptag = !m_pinc ? (m_pofs ? "R6" : "R4") : (m_pofs ? "R5" : "R3");
    chk(paddr === m_pa, ptag, "paddr", 64'(paddr), 64'(m_pa));
    chk(maddr === m_ma, "R3", "maddr", 64'(maddr), 64'(m_ma));
    chk(remain === m_rem, "R7", "remain", 64'(remain), 64'(m_rem));
    chk(last === (m_rem == 1), "R7", "last", 64'(last), 64'(m_rem == 1));
    chk(active === m_act, "R9", "active", 64'(active), 64'(m_act));
    chk(cfg_err === m_err, "R10", "cfg_err", 64'(cfg_err), 64'(m_err));
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d5eed));
    repeat (3) @(negedge clk);
    chk(paddr == 0 && maddr == 0 && remain == 0, "R1", "addr/count at reset",
        64'(paddr | maddr | AW'(remain)), 64'(0));
    chk(!last && !active && !cfg_err, "R1", "flags at reset",
        64'({last, active, cfg_err}), 64'(0));
    rst_n = 1;
    tick();

    // pofs4 with pinc off; setup change mid-transfer; beats past zero
    ps = 32'h1000; ms = 32'h2000; pinc = 0; minc = 1; psz = 2'b10; msz = 2'b01;
    pofs4 = 1; len = 3; en = 1; beat = 1;
    tick();
    chk(paddr == 32'h1000 && maddr == 32'h2000 && remain == 3 && active, "R2",
        "load values", 64'(maddr), 64'(32'h2000));
    msz = 2'b00; ms = '0; pinc = 1;
    repeat (3) tick();
    chk(paddr == 32'h1000, "R6", "paddr fixed with pofs4", 64'(paddr), 64'(32'h1000));
    chk(maddr == 32'h2006, "R11", "stride kept from load", 64'(maddr), 64'(32'h2006));
    chk(remain == 0, "R7", "count drained", 64'(remain), 64'(0));
    repeat (2) tick();
    chk(remain == 0 && maddr == 32'h2006, "R8", "beats at zero ignored",
        64'(remain), 64'(0));
    beat = 0; en = 0; tick();

    // override to 4 bytes on byte width, then freeze on disable
    ps = 32'h40; pinc = 1; pofs4 = 1; psz = 2'b00; msz = 2'b00; len = 5; en = 1;
    tick();
    beat = 1; tick();
    chk(paddr == 32'h44, "R5", "forced 4-byte stride", 64'(paddr), 64'(32'h44));
    en = 0; tick(); tick();
    chk(paddr == 32'h44 && remain == 4 && !active, "R9", "frozen after disable",
        64'(paddr), 64'(32'h44));
    beat = 0; tick();

    // reserved width
    psz = 2'b11; en = 1; tick();
    chk(cfg_err && !active, "R10", "reserved width refused", 64'({cfg_err, active}),
        64'(2'b10));
    beat = 1; tick();
    chk(remain == 4 && paddr == 32'h44, "R10", "no motion after refusal",
        64'(remain), 64'(4));
    beat = 0; en = 0; tick();

    // wrap at top of address space
    ps = '1; ms = '1 - 1; pinc = 1; pofs4 = 0; psz = 2'b00; minc = 1; msz = 2'b01;
    len = 2; en = 1; tick();
    beat = 1; tick();
    chk(paddr == 0 && maddr == 0, "R3", "modulo wrap", 64'(maddr), 64'(0));
    beat = 0; en = 0; tick();

    // constrained random transfers
    for (int it = 0; it < 400; it++) begin
      ps = $urandom; ms = $urandom;
      psz = ($urandom % 10 == 0) ? 2'b11 : 2'($urandom % 3);
      msz = ($urandom % 10 == 1) ? 2'b11 : 2'($urandom % 3);
      pinc = ($urandom % 4 == 0); minc = ($urandom % 4 != 0);
      pofs4 = $urandom % 2;
      len = ($urandom % 8 == 0) ? LW'($urandom) : LW'($urandom_range(0, 12));
      en = 1; beat = $urandom % 2;
      tick();
      for (int c = 0; c < int'($urandom_range(2, 20)); c++) begin
        beat = $urandom % 2;
        if ($urandom % 5 == 0) begin
          ps = $urandom; ms = $urandom; psz = 2'($urandom); msz = 2'($urandom);
          pinc = $urandom % 2; minc = $urandom % 2; pofs4 = $urandom % 2;
          len = LW'($urandom);
        end
        if ($urandom % 16 == 0) en = 0;
        tick();
      end
      en = 0; beat = $urandom % 2;
      tick();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule